// File: doc/BRIEF.md
# SPI Direct-Write Window

This block turns plain bus stores into SPI transmit traffic, with no polling of a status flag between bytes. The bus address space is split into two regions. The upper region is a set of address windows, one for each chip select. A store that lands in a window is shifted out on the SPI data line while that window's chip select is asserted. A full 32-bit store sends four bytes. A store flagged as a byte store sends only the low byte. The lower region holds a single configuration register. Its bit 0 chooses whether chip select is let go after every store or kept asserted between stores.

While the shifter is busy, the bus port holds `bus_ready` low, so the next store waits. Software can therefore stream a long command or payload to a flash or display device as a run of ordinary stores. In hold mode the device sees one unbroken chip-select frame across them. The path carries transmit data only, in 8-bit words, in SPI mode 0.

Top module: `spi_dwin`

## Requirements
- R1: After reset, `bus_ready` is 1, every `spi_cs_n` bit is 1, and `spi_sck` and `spi_mosi` are 0.
- R2: A store with `bus_addr[ADDR_W-1]`=1 and `bus_word`=0 sends `bus_wdata[7:0]`, most significant bit first. It goes out on the chip select whose index is `bus_addr[WIN_LSB +: log2(NUM_CS)]`.
- R3: A store with `bus_word`=1 sends four bytes from `bus_wdata`, least significant byte first. Within each byte the bits go out most significant bit first.
- R4: SPI mode 0 is used. `spi_sck` idles low and is high only while a chip select is asserted. `spi_mosi` is sampled by the receiver on the rising edge. Each SCK half period lasts DIV_HALF clock cycles.
- R5: `bus_ready` is low from the cycle after a window store is accepted until the last byte of that store has left the shifter.
- R6: A store with `bus_addr[ADDR_W-1]`=0 and low offset 0x20 writes `bus_wdata[0]` into the release bit, which is 0 after reset. Stores to any other register offset have no effect.
- R7: With the release bit at 0, chip select stays asserted after a store. A later store to the same chip select continues with no deassertion.
- R8: With the release bit at 1, chip select deasserts after the last byte of each store. It then stays high for at least 2*DIV_HALF cycles before `bus_ready` returns.
- R9: At most one chip select is asserted at any time. A store to a different chip select while one is held first deasserts the held one. All chip selects then stay high for at least 2*DIV_HALF cycles before the new one asserts.
- R10: Writing 1 to the release bit while a chip select is held deasserts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Store request |
| bus_addr | input | ADDR_W | Store address; top bit selects window region |
| bus_word | input | 1 | 1 = 32-bit store, 0 = byte store |
| bus_wdata | input | 32 | Store data |
| bus_ready | output | 1 | Store accepted when high together with bus_valid |
| spi_sck | output | 1 | SPI serial clock |
| spi_mosi | output | 1 | SPI transmit data |
| spi_cs_n | output | NUM_CS | Active-low chip selects |

## Verification
The bench builds the block with NUM_CS=4, DIV_HALF=3, ADDR_W=12 and WIN_LSB=8. Four chip selects are enough to switch between windows and exercise the deassert-then-reassert gap. A half period of three cycles makes the gap bound observably different from a single-cycle glitch, and each byte still lasts only about fifty cycles. A receiver model in the bench rebuilds bytes from SCK rising edges and compares them, paired with the active chip select, against the queue the store tasks fill. A separate monitor measures every high stretch on the chip selects between frames.

// File: rtl/spi_dwin_pkg.sv
package spi_dwin_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_GAP  = 2'd1,
        ST_SEND = 2'd2
    } dwin_st_e;

    localparam logic [7:0] CFG_OFS = 8'h20;
endpackage

// File: rtl/spi_dwin_tick.sv
module spi_dwin_tick #(
    parameter int DIV_HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic clr,
    output logic tick
);
    localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = en && (cnt_q == CW'(DIV_HALF - 1));
        cnt_d = cnt_q + CW'(1);
        if (clr || !en || tick)
            cnt_d = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/spi_dwin_shift.sv
module spi_dwin_shift (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] din,
    input  logic       tick,
    output logic       sck,
    output logic       mosi,
    output logic       done
);
    typedef struct packed {
        logic [7:0] sh;
        logic [2:0] cnt;
        logic       sck;
        logic       busy;
        logic       done;
    } shf_t;

    shf_t d, q;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (load) begin
            d.sh   = din;
            d.cnt  = '0;
            d.sck  = 1'b0;
            d.busy = 1'b1;
        end else if (q.busy && tick) begin
            if (!q.sck) begin
                d.sck = 1'b1;
            end else begin
                d.sck = 1'b0;
                d.sh  = {q.sh[6:0], 1'b0};
                d.cnt = q.cnt + 3'd1;
                if (q.cnt == 3'd7) begin
                    d.busy = 1'b0;
                    d.done = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sck  = q.sck;
    assign mosi = q.busy & q.sh[7];
    assign done = q.done;
endmodule

// File: rtl/spi_dwin.sv
module spi_dwin
    import spi_dwin_pkg::*;
#(
    parameter int NUM_CS   = 8,
    parameter int ADDR_W   = 12,
    parameter int WIN_LSB  = 8,
    parameter int DIV_HALF = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_word,
    input  logic [31:0]       bus_wdata,
    output logic              bus_ready,
    output logic              spi_sck,
    output logic              spi_mosi,
    output logic [NUM_CS-1:0] spi_cs_n
);
    localparam int CSW = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;
    localparam logic [WIN_LSB-1:0] CFG_SEL = WIN_LSB'(CFG_OFS);

    typedef struct packed {
        dwin_st_e       st;
        logic           rel;
        logic           cs_on;
        logic [CSW-1:0] cs_idx;
        logic [CSW-1:0] tgt;
        logic [31:0]    data;
        logic [2:0]     left;
        logic           pend;
        logic           gcnt;
    } ctl_t;

    ctl_t d, q;
    logic       load, clr, tick, sh_done;
    logic [7:0] ld_byte;
    logic       in_win;
    logic [CSW-1:0] win_idx;

    assign in_win  = bus_addr[ADDR_W-1];
    assign win_idx = bus_addr[WIN_LSB +: CSW];

    spi_dwin_tick #(.DIV_HALF(DIV_HALF)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (q.st != ST_IDLE),
        .clr  (clr),
        .tick (tick)
    );

    spi_dwin_shift u_shift (
        .clk  (clk),
        .rst_n(rst_n),
        .load (load),
        .din  (ld_byte),
        .tick (tick),
        .sck  (spi_sck),
        .mosi (spi_mosi),
        .done (sh_done)
    );

    always_comb begin
        d       = q;
        load    = 1'b0;
        clr     = 1'b0;
        ld_byte = q.data[7:0];
        unique case (q.st)
            ST_IDLE: begin
                if (bus_valid) begin
                    if (!in_win) begin
                        if (bus_addr[WIN_LSB-1:0] == CFG_SEL) begin
                            d.rel = bus_wdata[0];
                            if (bus_wdata[0] && q.cs_on) begin
                                d.cs_on = 1'b0;
                                d.st    = ST_GAP;
                                d.pend  = 1'b0;
                                d.gcnt  = 1'b0;
                                clr     = 1'b1;
                            end
                        end
                    end else begin
                        d.data = bus_wdata;
                        d.left = bus_word ? 3'd4 : 3'd1;
                        d.tgt  = win_idx;
                        if (q.cs_on && q.cs_idx != win_idx) begin
                            d.cs_on = 1'b0;
                            d.st    = ST_GAP;
                            d.pend  = 1'b1;
                            d.gcnt  = 1'b0;
                            clr     = 1'b1;
                        end else begin
                            d.cs_on  = 1'b1;
                            d.cs_idx = win_idx;
                            d.st     = ST_SEND;
                            load     = 1'b1;
                            ld_byte  = bus_wdata[7:0];
                        end
                    end
                end
            end
            ST_GAP: begin
                if (tick) begin
                    if (q.gcnt) begin
                        if (q.pend) begin
                            d.cs_on  = 1'b1;
                            d.cs_idx = q.tgt;
                            d.st     = ST_SEND;
                            load     = 1'b1;
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end else begin
                        d.gcnt = 1'b1;
                    end
                end
            end
            ST_SEND: begin
                if (sh_done) begin
                    if (q.left > 3'd1) begin
                        d.data  = {8'h00, q.data[31:8]};
                        d.left  = q.left - 3'd1;
                        load    = 1'b1;
                        ld_byte = q.data[15:8];
                    end else if (q.rel) begin
                        d.cs_on = 1'b0;
                        d.st    = ST_GAP;
                        d.pend  = 1'b0;
                        d.gcnt  = 1'b0;
                        clr     = 1'b1;
                    end else begin
                        d.st = ST_IDLE;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign bus_ready = (q.st == ST_IDLE);

    for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
        assign spi_cs_n[i] = !(q.cs_on && (q.cs_idx == CSW'(i)));
    end
endmodule

// File: rtl/spi_dwin_chk.sv
module spi_dwin_chk #(
    parameter int NUM_CS = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_ready,
    input logic              spi_sck,
    input logic [NUM_CS-1:0] spi_cs_n
);
    p_cs_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~spi_cs_n));

    p_sck_in_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sck |-> (~spi_cs_n != '0));

    p_busy_while_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sck |-> !bus_ready);

    p_idle_cs_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ready && !bus_valid) |=> $stable(spi_cs_n));
endmodule

bind spi_dwin spi_dwin_chk #(.NUM_CS(NUM_CS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_valid(bus_valid),
    .bus_ready(bus_ready),
    .spi_sck  (spi_sck),
    .spi_cs_n (spi_cs_n)
);

// File: tb/spi_dwin_bench.sv
module spi_dwin_bench;
    localparam int NCS  = 4;
    localparam int AW   = 12;
    localparam int WLSB = 8;
    localparam int DIVH = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_valid = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_word = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic          bus_ready, spi_sck, spi_mosi;
    logic [NCS-1:0] spi_cs_n;

    int checks = 0;
    int errors = 0;
    bit done_flag = 1'b0;
    logic [15:0] exp_q[$];

    always #2 clk = ~clk;

    spi_dwin #(.NUM_CS(NCS), .ADDR_W(AW), .WIN_LSB(WLSB), .DIV_HALF(DIVH)) u_spi_dwin (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_addr(bus_addr),
        .bus_word(bus_word), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
        .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // receiver model: rebuild bytes on SCK rising edges
    logic [7:0] rx_sh = '0;
    int         rx_bits = 0;
    always @(posedge spi_sck) begin
        int cs_seen;
        logic [15:0] e;
        cs_seen = -1;
        for (int i = 0; i < NCS; i++) if (!spi_cs_n[i]) cs_seen = i;
        rx_sh = {rx_sh[6:0], spi_mosi};
        rx_bits++;
        if (rx_bits == 8) begin
            rx_bits = 0;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2/R3", "unexpected byte", {16'h0, 8'(cs_seen), rx_sh}, 32'h0);
            end else begin
                e = exp_q.pop_front();
                chk({8'(cs_seen), rx_sh} == e, "R2/R3", "cs and byte",
                    {16'h0, 8'(cs_seen), rx_sh}, {16'h0, e});
            end
        end
    end

    // chip-select gap monitor
    int hi_len = 0;
    int assert_events = 0;
    bit seen_act = 1'b0;
    bit prev_act = 1'b0;
    logic [NCS-1:0] prev_cs = '1;
    always @(negedge clk) begin
        bit act;
        act = (spi_cs_n != '1);
        if (rst_n) begin
            if (!act) begin
                hi_len++;
            end else begin
                if (!prev_act) begin
                    if (seen_act)
                        chk(hi_len >= 2 * DIVH, "R8/R9", "cs high gap", hi_len, 2 * DIVH);
                    assert_events++;
                    seen_act = 1'b1;
                end else if (spi_cs_n != prev_cs) begin
                    chk(1'b0, "R9", "cs switched without gap", spi_cs_n, prev_cs);
                end
                hi_len = 0;
            end
        end
        prev_act = act;
        prev_cs  = spi_cs_n;
    end

    task automatic bus_wr(input logic [AW-1:0] a, input logic [31:0] dat, input bit w);
        @(negedge clk);
        bus_valid = 1'b1; bus_addr = a; bus_wdata = dat; bus_word = w;
        while (!bus_ready) @(negedge clk);
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (!bus_ready) @(negedge clk);
    endtask

    task automatic store(input int cs, input logic [31:0] dat, input bit w);
        int n;
        n = w ? 4 : 1;
        for (int i = 0; i < n; i++) exp_q.push_back({8'(cs), dat[8*i +: 8]});
        bus_wr(AW'((1 << (AW - 1)) | (cs << WLSB)), dat, w);
        wait_idle();
        chk(exp_q.size() == 0, "R5", "all bytes out when ready returns", exp_q.size(), 0);
    endtask

    task automatic cfg(input logic [7:0] ofs, input logic [31:0] dat);
        bus_wr(AW'(ofs), dat, 1'b1);
        wait_idle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int ev;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(bus_ready == 1'b1, "R1", "ready after reset", bus_ready, 1);
        chk(spi_cs_n == '1, "R1", "cs_n after reset", spi_cs_n, 4'hF);
        chk(spi_sck == 1'b0, "R1", "sck after reset", spi_sck, 0);
        chk(spi_mosi == 1'b0, "R1", "mosi after reset", spi_mosi, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2 byte store, R7 hold mode (reset default)
        store(1, 32'h0000_00A5, 1'b0);
        chk(spi_cs_n == 4'b1101, "R7", "cs1 held after store", spi_cs_n, 4'b1101);
        ev = assert_events;
        store(1, 32'h0000_003C, 1'b0);
        chk(assert_events == ev, "R7", "no reassert on same cs", assert_events, ev);

        // R3 word store, LS byte first
        store(1, 32'h1122_3344, 1'b1);
        chk(spi_cs_n == 4'b1101, "R7", "cs1 held after word", spi_cs_n, 4'b1101);

        // R9 switch to another chip select while held
        store(2, 32'h0000_0081, 1'b0);
        chk(spi_cs_n == 4'b1011, "R9", "cs2 now held alone", spi_cs_n, 4'b1011);

        // R6 write to another register offset is ignored
        cfg(8'h24, 32'h1);
        repeat (10) @(negedge clk);
        chk(spi_cs_n == 4'b1011, "R6", "offset 0x24 ignored", spi_cs_n, 4'b1011);

        // R10 set release bit drops held cs
        cfg(8'h20, 32'h1);
        chk(spi_cs_n == 4'hF, "R10", "cs released by config", spi_cs_n, 4'hF);

        // R8 release mode
        store(3, 32'hDEAD_BEEF, 1'b1);
        chk(spi_cs_n == 4'hF, "R8", "cs released after word", spi_cs_n, 4'hF);
        store(0, 32'h0000_005A, 1'b0);
        chk(spi_cs_n == 4'hF, "R8", "cs released after byte", spi_cs_n, 4'hF);

        // R6 back to hold via offset 0x20
        cfg(8'h20, 32'h0);
        store(0, 32'h0000_000F, 1'b0);
        chk(spi_cs_n == 4'b1110, "R6", "hold restored", spi_cs_n, 4'b1110);
        store(0, 32'h8001_7FFE, 1'b1);
        chk(spi_cs_n == 4'b1110, "R7", "cs0 still held", spi_cs_n, 4'b1110);

        repeat (20) @(negedge clk);
        chk(exp_q.size() == 0, "R2", "scoreboard drained", exp_q.size(), 0);
        chk(spi_sck == 1'b0, "R4", "sck idles low", spi_sck, 0);
        done_flag = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule